// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block stands between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate: an ID, an 8-bit priority (lower is more urgent) and a flag that marks edge-triggered sources. The interface compares that candidate against a software-set priority threshold and against the priority of the interrupt the processor is already servicing. It raises the processor's request line only when the candidate would really preempt.

Software talks to the block through a small register port. Reading the acknowledge register claims the candidate: it returns the ID, tells the distributor to mark the source active, and for edge sources to drop its pending state. It also makes the candidate's priority the new running priority. Writing the same ID to the completion register retires it. Acknowledged interrupts nest in a small stack of depth `DEPTH`, so a completion brings back the priority of the interrupt that was preempted. When the last one completes, the running priority returns to idle.

Register map (3-bit address): 0 control, 1 priority threshold, 2 acknowledge (read), 3 completion (write), 4 running priority (read). Read data appears on `reg_rdata` in the cycle after the read.

Top module: `icpu_ack_if`

## Requirements
- R1: After reset the control bit and the threshold read as 0, the running priority reads 0xFF and `irq` is low.
- R2: Bit 0 of the control register (address 0) gates `irq`; with it clear `irq` stays low whatever the candidate.
- R3: The threshold register (address 1, bits 7:0) passes a candidate only when its priority is strictly lower than the threshold; equal or higher priority is never signalled.
- R4: A read of address 2 with a qualifying candidate returns its ID in bits 9:0 with all upper bits zero, and pulses `act_set` with `act_id` in the read cycle. This works whether or not the control bit is set.
- R5: `pend_clr` pulses together with `act_set` only when the acknowledged candidate has `cand_edge` set; level candidates leave it low.
- R6: When no candidate qualifies, an acknowledge read returns 1023 and changes no state. A candidate does not qualify when `cand_valid` is low, when its priority fails R3 or R8, or when its ID is 1020 or above.
- R7: A successful acknowledge makes the candidate's priority the running priority, readable at address 4 in bits 7:0.
- R8: `irq` asserts only when the candidate's priority is strictly lower than the running priority.
- R9: Writing the most recently acknowledged active ID to address 3 pulses `done_valid` with `done_id` and retires it. The running priority falls back to the priority of the previous active interrupt, or to 0xFF when none is left.
- R10: A completion write whose ID is not the most recently acknowledged active ID is ignored: no `done_valid` and no change in running priority.
- R11: `irq` reflects a register write from the cycle after that write's clock edge, and not before.
- R12: With `DEPTH` interrupts active, an acknowledge read returns 1023 and the running priority is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_edge | input | 1 | Candidate is edge-triggered |
| irq | output | 1 | Interrupt request to the processor |
| act_set | output | 1 | Acknowledge accepted: mark act_id active |
| act_id | output | 10 | ID being acknowledged |
| pend_clr | output | 1 | Clear the pending state of act_id (edge source) |
| done_valid | output | 1 | Completion accepted |
| done_id | output | 10 | ID being retired |

## Verification
The assertions watch the cycle-level invariants on every clock. The request line never rises for a candidate that fails to beat the running priority. An accepted acknowledge loads the running priority on the next edge, and a spurious acknowledge leaves it untouched. A rejected completion leaves the nesting depth alone, `pend_clr` never appears without `act_set`, and the stack never takes a push while full. The directed scenarios are needed for the rest: the returned IDs and the 1023 value, the strict threshold comparison at its boundary, and the control gate. They also cover the one-cycle lag of `irq` after a register write and the restoration order through a full stack of nested interrupts.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ID_W-1:0]   ID_SPURIOUS  = 10'd1023;
  localparam logic [ID_W-1:0]   ID_FIRST_RSV = 10'd1020;
  localparam logic [PRIO_W-1:0] PRIO_IDLE    = 8'hFF;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_THR   = 3'd1,
    SEL_CLAIM = 3'd2,
    SEL_DONE  = 3'd3,
    SEL_RUN   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } act_ent_t;

  // strict urgency: numerically lower wins
  function automatic logic beats(input logic [PRIO_W-1:0] a,
                                 input logic [PRIO_W-1:0] b);
    return a < b;
  endfunction

  function automatic logic id_usable(input logic [ID_W-1:0] id);
    return id < ID_FIRST_RSV;
  endfunction
endpackage

// File: rtl/icpu_regs.sv
module icpu_regs
  import icpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              qualify,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] thr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_word;
  logic [ID_W-1:0]   claim_id;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:PRIO_W];
  assign claim_id     = qualify ? cand_id : ID_SPURIOUS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      thr     <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) ctrl_en <= wdata[0];
      if (sel == SEL_THR)  thr     <= wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTRL:  rd_word[0]          = ctrl_en;
      SEL_THR:   rd_word[PRIO_W-1:0] = thr;
      SEL_CLAIM: rd_word[ID_W-1:0]   = claim_id;
      SEL_RUN:   rd_word[PRIO_W-1:0] = run_prio;
      default:   rd_word             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/icpu_prio_gate.sv
module icpu_prio_gate
  import icpu_pkg::*;
(
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] thr,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  input  logic              ctrl_en,
  output logic              qualify,
  output logic              irq
);
  logic pass_thr;
  logic pass_run;

  assign pass_thr = beats(cand_prio, thr);
  assign pass_run = beats(cand_prio, run_prio);
  assign qualify  = cand_valid && id_usable(cand_id) && pass_thr && pass_run && !stack_full;
  assign irq      = ctrl_en && qualify;
endmodule

// File: rtl/icpu_active_stack.sv
module icpu_active_stack
  import icpu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  act_ent_t          push_ent,
  input  logic              done_req,
  input  logic [ID_W-1:0]   done_id,
  output logic              pop_ok,
  output logic              empty,
  output logic              full,
  output logic [PRIO_W-1:0] run_prio
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  act_ent_t         ents_q [DEPTH];
  act_ent_t         top_ent;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    top_ent = '{id: '0, prio: PRIO_IDLE};
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CNT_W'(i + 1)) top_ent = ents_q[i];
  end

  assign pop_ok   = done_req && !empty && (done_id == top_ent.id);
  assign run_prio = empty ? PRIO_IDLE : top_ent.prio;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ents_q[g] <= '{id: '0, prio: PRIO_IDLE};
      else if (push && cnt_q == CNT_W'(g))    ents_q[g] <= push_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (push && !full)  cnt_q <= cnt_q + 1'b1;
    else if (pop_ok)         cnt_q <= cnt_q - 1'b1;
  end

  // R12: the gate must never offer a push to a full stack
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R9: retiring the last entry returns to idle priority
  p_last_pop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && cnt_q == CNT_W'(1)) |=> (run_prio == PRIO_IDLE));
  // R10: a rejected completion leaves the depth alone
  p_bad_done_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_req && !pop_ok && !push) |=> $stable(cnt_q));
endmodule

// File: rtl/icpu_ack_if.sv
module icpu_ack_if
  import icpu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_edge,
  output logic              irq,
  output logic              act_set,
  output logic [ID_W-1:0]   act_id,
  output logic              pend_clr,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  reg_sel_e          sel;
  logic              rd_only;
  logic              ctrl_en;
  logic [PRIO_W-1:0] thr;
  logic [PRIO_W-1:0] run_prio;
  logic              qualify;
  logic              stack_full;
  logic              stack_empty;
  logic              claim_fire;
  logic              claim_spur;
  logic              done_req;
  logic              pop_ok;
  act_ent_t          push_ent;

  assign sel        = reg_sel_e'(reg_addr);
  assign rd_only    = reg_rd && !reg_wr;
  assign claim_fire = rd_only && (sel == SEL_CLAIM) && qualify;
  assign claim_spur = rd_only && (sel == SEL_CLAIM) && !qualify;
  assign done_req   = reg_wr && (sel == SEL_DONE);
  assign push_ent   = '{id: cand_id, prio: cand_prio};

  icpu_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .rd_en    (rd_only),
    .sel      (sel),
    .wdata    (reg_wdata),
    .qualify  (qualify),
    .cand_id  (cand_id),
    .run_prio (run_prio),
    .ctrl_en  (ctrl_en),
    .thr      (thr),
    .rdata    (reg_rdata)
  );

  icpu_prio_gate u_gate (
    .cand_valid (cand_valid),
    .cand_id    (cand_id),
    .cand_prio  (cand_prio),
    .thr        (thr),
    .run_prio   (run_prio),
    .stack_full (stack_full),
    .ctrl_en    (ctrl_en),
    .qualify    (qualify),
    .irq        (irq)
  );

  icpu_active_stack #(.DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (claim_fire),
    .push_ent (push_ent),
    .done_req (done_req),
    .done_id  (reg_wdata[ID_W-1:0]),
    .pop_ok   (pop_ok),
    .empty    (stack_empty),
    .full     (stack_full),
    .run_prio (run_prio)
  );

  assign act_set    = claim_fire;
  assign act_id     = cand_id;
  assign pend_clr   = claim_fire && cand_edge;
  assign done_valid = pop_ok;
  assign done_id    = reg_wdata[ID_W-1:0];

  // R8: the request line never rises without beating the running priority
  p_irq_beats_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cand_prio < run_prio));
  // R7: an accepted claim installs the candidate priority
  p_claim_loads_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> (run_prio == $past(cand_prio)));
  // R6: a spurious claim changes nothing
  p_spur_keeps_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_spur |=> $stable(run_prio));
  // R5: pending clear only accompanies an accepted claim
  p_pend_with_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> act_set);
  // R1: empty nesting means idle priority
  p_idle_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stack_empty |-> (run_prio == PRIO_IDLE));
endmodule

// File: tb/icpu_ack_if_tb.sv
module icpu_ack_if_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cand_valid = 1'b0, cand_edge = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic        irq, act_set, pend_clr, done_valid;
  logic [9:0]  act_id, done_id;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  icpu_ack_if #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
    .cand_edge(cand_edge), .irq(irq), .act_set(act_set), .act_id(act_id),
    .pend_clr(pend_clr), .done_valid(done_valid), .done_id(done_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d,
                    output logic irq_before, output logic done_seen);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    irq_before = irq;
    done_seen  = done_valid;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d,
                    output logic set_seen, output logic clr_seen);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    set_seen = act_set;
    clr_seen = pend_clr;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p, input logic e);
    cand_valid = v; cand_id = id; cand_prio = p; cand_edge = e;
    #1;
  endtask

  function automatic logic [7:0] exp_run(input int depth, input logic [7:0] top);
    return (depth == 0) ? 8'hFF : top;
  endfunction

  task automatic t_reset;
    logic [31:0] d; logic s, c;
    chk("R1 irq", irq, 0);
    rd(3'd0, d, s, c); chk("R1 ctrl", d, 0);
    rd(3'd1, d, s, c); chk("R1 thr", d, 0);
    rd(3'd4, d, s, c); chk("R1 run", d, 32'hFF);
  endtask

  task automatic t_threshold;
    logic b, dn;
    offer(1, 10'd40, 8'h40, 0);
    wr(3'd0, 32'h1, b, dn);
    wr(3'd1, 32'h30, b, dn);
    chk("R3 above thr", irq, 0);
    wr(3'd1, 32'h50, b, dn);
    chk("R11 before edge", b, 0);
    chk("R11 after edge", irq, 1);
    wr(3'd1, 32'h40, b, dn);
    chk("R3 equal thr", irq, 0);
    wr(3'd1, 32'h41, b, dn);
    chk("R3 just below", irq, 1);
    wr(3'd0, 32'h0, b, dn);
    chk("R2 disabled", irq, 0);
    wr(3'd0, 32'h1, b, dn);
    chk("R2 enabled", irq, 1);
  endtask

  task automatic t_claim_nest;
    logic [31:0] d; logic s, c, b, dn;
    wr(3'd1, 32'hF0, b, dn);
    offer(1, 10'd45, 8'h40, 0);
    rd(3'd2, d, s, c);
    chk("R4 claim id", d, 45);
    chk("R4 act_set", s, 1);
    chk("R5 level no clr", c, 0);
    rd(3'd4, d, s, c); chk("R7 run", d, exp_run(1, 8'h40));
    chk("R8 no preempt same prio", irq, 0);
    offer(1, 10'd50, 8'h20, 1);
    chk("R8 preempt", irq, 1);
    rd(3'd2, d, s, c);
    chk("R4 nested id", d, 50);
    chk("R5 edge clr", c, 1);
    wr(3'd3, 32'd45, b, dn);
    chk("R10 wrong id no done", dn, 0);
    rd(3'd4, d, s, c); chk("R10 run kept", d, 32'h20);
    wr(3'd3, 32'd50, b, dn);
    chk("R9 done", dn, 1);
    rd(3'd4, d, s, c); chk("R9 restore prev", d, 32'h40);
    wr(3'd3, 32'd45, b, dn);
    rd(3'd4, d, s, c); chk("R9 restore idle", d, 32'hFF);
    wr(3'd3, 32'd45, b, dn);
    chk("R10 none active", dn, 0);
  endtask

  task automatic t_spurious;
    logic [31:0] d; logic s, c;
    offer(0, 10'd7, 8'h10, 0);
    rd(3'd2, d, s, c);
    chk("R6 no cand", d, 1023); chk("R6 no act_set", s, 0);
    offer(1, 10'd1021, 8'h10, 0);
    rd(3'd2, d, s, c); chk("R6 reserved id", d, 1023);
    offer(1, 10'd1019, 8'hF0, 0);
    rd(3'd2, d, s, c); chk("R6 at threshold", d, 1023);
    rd(3'd4, d, s, c); chk("R6 run unchanged", d, 32'hFF);
  endtask

  task automatic t_full;
    logic [31:0] d; logic s, c, b, dn;
    logic [7:0] pr [DEPTH];
    wr(3'd0, 32'h0, b, dn);
    for (int i = 0; i < DEPTH; i++) begin
      pr[i] = 8'h60 - 8'(i * 16);
      offer(1, 10'(100 + i), pr[i], 0);
      rd(3'd2, d, s, c);
      chk("R4 claim while disabled", d, 100 + i);
    end
    offer(1, 10'd200, 8'h01, 0);
    rd(3'd2, d, s, c); chk("R12 full spurious", d, 1023);
    rd(3'd4, d, s, c); chk("R12 run kept", d, {24'h0, pr[DEPTH-1]});
    for (int i = DEPTH - 1; i >= 0; i--) begin
      wr(3'd3, 32'(100 + i), b, dn);
      chk("R9 unwind done", dn, 1);
      rd(3'd4, d, s, c);
      chk("R9 unwind run", d, {24'h0, exp_run(i, (i > 0) ? pr[(i > 0) ? i - 1 : 0] : 8'h00)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_claim_nest();
    t_spurious();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule